// File: doc/BRIEF.md
# Shared Pulse Sample-Start Synchronizer

This block lets several acquisition modules sample in lock-step by pacing the local conversion sequence from a common sample-start pulse instead of a local timebase. The pulse arrives on an asynchronous general-purpose pin once per sample period (nominally 30 kHz). It is brought into the local clock domain, and each rising edge becomes one single-cycle internal sample-start strobe. Because every strobe is tied to an external edge, a module whose oscillator drifts still produces exactly one sample per shared pulse. Each strobe lands a few local clock cycles after its pulse, far inside a microsecond.

Software first arms the block. It then waits, without a deadline, for the first pulse. That pulse starts acquisition, and from then on every pulse starts one sample until a halt command is given. The halt is honoured at the next pulse boundary. While acquiring, the block watches two things. If the gap between pulses grows longer than a programmable limit, it sets a sticky missed-pulse flag and keeps waiting. If a pulse arrives while the downstream sequence still reports busy, it drops that pulse and sets a sticky overrun flag.

Top module: `pulse_lock_sampler`

## Requirements
- R1: After a synchronous active-low reset, `sample_start`, `acquiring`, `missed_flag` and `overrun_flag` are all 0.
- R2: While idle (not armed), pulses on `pulse_in` produce no strobe and leave `acquiring` at 0.
- R3: After `arm` is accepted, no strobe is issued and `acquiring` stays 0 until the first rising edge of `pulse_in`, however long that takes.
- R4: A rising edge of `pulse_in` that is stable before clock edge E produces `sample_start` high for exactly one cycle after edge E+2, which is three clock edges after the pulse. `acquiring` rises with the first such strobe.
- R5: While acquiring, with `seq_busy` low and no halt pending, every separate pulse (high for at least one cycle, low for at least one cycle) produces exactly one strobe.
- R6: A pulse held high for many cycles produces only one strobe. Strobes come from rising edges only.
- R7: `arm` is ignored while acquiring: `acquiring` stays 1, strobes continue, and the sticky flags are not cleared.
- R8: A pulse edge that arrives while acquiring with `seq_busy` high produces no strobe and sets `overrun_flag`, which stays set.
- R9: While acquiring, if more than `gap_limit` cycles pass after a pulse edge without another edge, `missed_flag` is set and stays set. `acquiring` stays 1, and the next pulse still produces a strobe.
- R10: A one-cycle `halt` while acquiring takes effect at the next pulse edge. That edge produces no strobe, and `acquiring` falls with it. Until then, `acquiring` stays 1.
- R11: An `arm` accepted in idle clears both `missed_flag` and `overrun_flag`.
- R12: A `halt` while armed but not yet started returns the block to idle at once, so a following pulse produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Asynchronous shared sample-start pulse |
| arm | input | 1 | Arm request, taken only while idle |
| halt | input | 1 | Halt request, honoured at the next pulse boundary |
| seq_busy | input | 1 | Downstream sample sequence still running |
| gap_limit | input | GAP_W | Missed-pulse timeout in clock cycles |
| sample_start | output | 1 | One-cycle strobe that starts a local sample |
| acquiring | output | 1 | Block is in the running state |
| missed_flag | output | 1 | Sticky: the pulse gap exceeded `gap_limit` |
| overrun_flag | output | 1 | Sticky: a pulse came while `seq_busy` was high |

## Verification
The hardest case to reach from the ports is the interaction between a pending halt and the pulse stream. The halt is only observable through a dropped strobe and the fall of `acquiring` at a later, asynchronously timed edge. A closely related case is `arm` arriving while running with a sticky flag already set. The stimulus reaches these by first building the run state with random pulse widths and gaps, then forcing an overrun with `seq_busy`, then issuing `arm` and `halt` at chosen phases between pulses. Each step checks both the strobe count and the flags.

// File: rtl/pls_pkg.sv
// Package: shared state encoding and defaults for the pulse-lock sampler.
// Assumes a 100 MHz local clock for the recommended timeout value.
package pls_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } pls_state_e;

    // Recommended gap limit: about 1.5 periods of 30 kHz at 100 MHz.
    localparam int unsigned GAP_DEFAULT = 5000;
endpackage

// File: rtl/pls_edge_sync.sv
// Module: pls_edge_sync
// Brings an asynchronous pin into the clock domain through STAGES flops
// and flags each rising edge for one cycle. Assumes STAGES >= 2.
module pls_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise
);
    logic [STAGES:0] chain_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin_async};
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // A rising edge is never reported on two consecutive cycles.
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pls_gap_watch.sv
// Module: pls_gap_watch
// Counts cycles since the last pulse edge while running and raises a
// sticky flag once the count reaches the limit. The counter saturates.
module pls_gap_watch #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rise,
    input  logic             clr,
    input  logic [GAP_W-1:0] limit,
    output logic             missed
);
    logic [GAP_W-1:0] cnt_q;
    logic             hit;

    assign hit = run && !rise && (cnt_q == limit);

    // Gap counter: cleared by edges and outside the running state.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!run || rise)       cnt_q <= '0;
        else if (cnt_q != limit)     cnt_q <= cnt_q + 1'b1;
    end

    // Sticky missed flag, cleared only by an accepted arm.
    always_ff @(posedge clk) begin
        if (!rst_n)    missed <= 1'b0;
        else if (clr)  missed <= 1'b0;
        else if (hit)  missed <= 1'b1;
    end

    assert_missed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (missed && !clr) |=> missed);
    assert_missed_only_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(missed) |-> $past(run));
endmodule

// File: rtl/pls_ctrl.sv
// Module: pls_ctrl
// Idle/armed/running sequencer. It turns synchronized pulse edges into
// sample strobes, defers a halt to the next edge and flags overruns.
// Assumes rise is already one cycle wide and in the clock domain.
module pls_ctrl
    import pls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic arm,
    input  logic halt,
    input  logic seq_busy,
    output logic strobe,
    output logic run,
    output logic arm_take,
    output logic overrun
);
    pls_state_e state_q, state_d;
    logic       halt_pend_q;
    logic       strobe_d;
    logic       ovr_hit;

    assign arm_take = (state_q == ST_IDLE) && arm;
    assign run      = (state_q == ST_RUN);
    assign ovr_hit  = run && rise && !(halt_pend_q || halt) && seq_busy;

    // Next-state and strobe decision.
    always_comb begin
        state_d  = state_q;
        strobe_d = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (arm) state_d = ST_ARMED;
            ST_ARMED: begin
                if (halt) state_d = ST_IDLE;
                else if (rise) begin
                    state_d  = ST_RUN;
                    strobe_d = 1'b1;
                end
            end
            ST_RUN: begin
                if (rise) begin
                    if (halt_pend_q || halt) state_d = ST_IDLE;
                    else if (!seq_busy)      strobe_d = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            strobe  <= 1'b0;
        end else begin
            state_q <= state_d;
            strobe  <= strobe_d;
        end
    end

    // Pending halt: remembered until the next boundary leaves the run state.
    always_ff @(posedge clk) begin
        if (!rst_n)                  halt_pend_q <= 1'b0;
        else if (!run)               halt_pend_q <= 1'b0;
        else if (rise)               halt_pend_q <= 1'b0;
        else if (halt)               halt_pend_q <= 1'b1;
    end

    // Sticky overrun flag, cleared only by an accepted arm.
    always_ff @(posedge clk) begin
        if (!rst_n)        overrun <= 1'b0;
        else if (arm_take) overrun <= 1'b0;
        else if (ovr_hit)  overrun <= 1'b1;
    end

    assert_arm_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halt_pend_q && !halt) |=> run);
    assert_halt_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rise) |=> run);
    assert_overrun_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(seq_busy));
    assert_armed_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !rise) |=> !strobe);
endmodule

// File: rtl/pulse_lock_sampler.sv
// Module: pulse_lock_sampler
// Top level: paces local sampling from a shared asynchronous pulse.
// Assumes the pulse stays high and stays low for at least one clock each.
module pulse_lock_sampler #(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             arm,
    input  logic             halt,
    input  logic             seq_busy,
    input  logic [GAP_W-1:0] gap_limit,
    output logic             sample_start,
    output logic             acquiring,
    output logic             missed_flag,
    output logic             overrun_flag
);
    logic rise;
    logic run;
    logic arm_take;

    pls_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pulse_in),
        .rise      (rise)
    );

    pls_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .arm      (arm),
        .halt     (halt),
        .seq_busy (seq_busy),
        .strobe   (sample_start),
        .run      (run),
        .arm_take (arm_take),
        .overrun  (overrun_flag)
    );

    pls_gap_watch #(.GAP_W(GAP_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .rise   (rise),
        .clr    (arm_take),
        .limit  (gap_limit),
        .missed (missed_flag)
    );

    assign acquiring = run;

    assert_strobe_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_start |-> acquiring);
    assert_strobe_from_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_start |-> $past(rise));
endmodule

// File: tb/pulse_lock_sampler_bench.sv
module pulse_lock_sampler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GAP_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse_in = 1'b0;
    logic             arm = 1'b0;
    logic             halt = 1'b0;
    logic             seq_busy = 1'b0;
    logic [GAP_W-1:0] gap_limit = 16'd100;
    logic             sample_start, acquiring, missed_flag, overrun_flag;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int seed = 12345;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_lock_sampler #(.GAP_W(GAP_W)) u_pulse_lock_sampler (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .arm(arm), .halt(halt),
        .seq_busy(seq_busy), .gap_limit(gap_limit), .sample_start(sample_start),
        .acquiring(acquiring), .missed_flag(missed_flag), .overrun_flag(overrun_flag)
    );

    always @(negedge clk) if (sample_start) strobes++;

    // Expected strobe count after n clean pulses in the running state.
    function automatic int exp_after(input int base, input int n, input bit busy);
        return busy ? base : base + n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int width, input int gap);
        @(negedge clk); pulse_in = 1'b1;
        repeat (width) @(negedge clk);
        pulse_in = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic tap_arm();
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic tap_halt();
        @(negedge clk); halt = 1'b1;
        @(negedge clk); halt = 1'b0;
    endtask

    initial begin
        int base;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 strobe", sample_start, 0);
        check("R1 acquiring", acquiring, 0);
        check("R1 flags", {missed_flag, overrun_flag}, 0);
        rst_n = 1'b1;

        // R2: pulses while idle
        pulse(2, 8); pulse(3, 8);
        check("R2 strobes", strobes, 0);
        check("R2 acquiring", acquiring, 0);

        // R3: armed, long wait with no pulse
        tap_arm();
        repeat (300) @(negedge clk);
        check("R3 strobes", strobes, 0);
        check("R3 acquiring", acquiring, 0);
        check("R3 no missed while armed", missed_flag, 0);

        // R4: latency of the first strobe
        @(negedge clk); pulse_in = 1'b1;
        @(negedge clk); check("R4 cycle1", sample_start, 0);
        @(negedge clk); check("R4 cycle2", sample_start, 0);
        @(negedge clk); check("R4 cycle3", sample_start, 1);
        check("R4 acquiring", acquiring, 1);
        @(negedge clk); check("R4 one cycle", sample_start, 0);
        pulse_in = 1'b0;
        repeat (6) @(negedge clk);

        // R5: random pulse train
        base = strobes;
        for (int i = 0; i < 40; i++) begin
            pulse(1 + int'($urandom_range(3)), 6 + int'($urandom_range(24)));
        end
        check("R5 count", strobes, exp_after(base, 40, 1'b0));
        check("R5 no missed", missed_flag, 0);

        // R6: long high pulse gives one strobe
        base = strobes;
        pulse(40, 8);
        check("R6 count", strobes, exp_after(base, 1, 1'b0));

        // R8: overrun while busy
        base = strobes;
        seq_busy = 1'b1;
        pulse(2, 8);
        seq_busy = 1'b0;
        check("R8 strobes", strobes, exp_after(base, 1, 1'b1));
        check("R8 overrun", overrun_flag, 1);
        check("R8 still acquiring", acquiring, 1);

        // R7: arm ignored while acquiring
        tap_arm();
        check("R7 acquiring", acquiring, 1);
        check("R7 overrun kept", overrun_flag, 1);
        base = strobes;
        pulse(2, 8);
        check("R7 strobes continue", strobes, exp_after(base, 1, 1'b0));

        // R9: gap longer than limit
        repeat (200) @(negedge clk);
        check("R9 missed", missed_flag, 1);
        check("R9 acquiring", acquiring, 1);
        base = strobes;
        pulse(2, 8);
        check("R9 next strobe", strobes, exp_after(base, 1, 1'b0));
        check("R9 missed sticky", missed_flag, 1);

        // R10: halt at next boundary
        tap_halt();
        repeat (20) @(negedge clk);
        check("R10 still acquiring", acquiring, 1);
        base = strobes;
        pulse(2, 8);
        check("R10 boundary strobe dropped", strobes, base);
        check("R10 acquiring", acquiring, 0);

        // R11: arm from idle clears flags
        tap_arm();
        check("R11 missed cleared", missed_flag, 0);
        check("R11 overrun cleared", overrun_flag, 0);

        // R12: halt while armed
        tap_halt();
        base = strobes;
        pulse(2, 8);
        check("R12 strobes", strobes, base);
        check("R12 acquiring", acquiring, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule